// File: doc/BRIEF.md
# 24-Pin GPIO Controller with Pin Interrupts

This block gives a host 24 general-purpose pins through a synchronous 16-bit register port. A pin is either an output, driven from a data register, or an input. Input values pass through a two-flop synchronizer. An input can raise an interrupt on a high level, a low level, a rising edge, a falling edge, or either edge.

Each pin's detection sets a sticky status bit, which software clears by writing a 1 to it. Status bits are masked by a per-pin enable and ORed into one active-high interrupt line. Each 24-bit register is reached as two 16-bit halves; the high half sits at word address offset 8 from the low half.

The trigger settings are held in three 16-bit registers, one per group of eight pins. In each, the low byte carries polarity and the high byte carries the both-edge flag. A write takes effect on the clock edge that samples `wr`. A read is captured on the edge that samples `rd` and appears on `rdata` after that edge; `rdata` holds until the next read.

Top module: `pin_irq_gpio`

## Requirements
- R1: Word address 1 (low, bits 15:0) and 9 (high, bits 23:16) hold the direction register. A 1 makes the pin an output: `pin_oe` is 1 and `pin_out` carries the data register bit. A 0 makes it an input with `pin_oe` 0.
- R2: Every 24-bit register is split into two halves. The low half at address A holds bits 15:0. The high half at A+8 holds bits 23:16 in `wdata[7:0]` and `rdata[7:0]`, and a read of a high half returns 0 in `rdata[15:8]`. The registers are: data at 0, direction at 1, type at 2, enable at 3 and status at 4.
- R3: A read of data (address 0/8) returns the driven value for output pins and the synchronized input for input pins. A pin change made before edge e0 is first seen by a read captured at edge e2, not by one captured at e0 or e1.
- R4: With the type bit 0 (level mode), a polarity bit of 1 sets status while the pin is 1, and a polarity bit of 0 sets it while the pin is 0. The status bit is set again on every clock while the condition holds, even right after a clear.
- R5: With the type bit 1 (edge mode) and the both-edge flag 0, a polarity bit of 1 sets status on a 0-to-1 change and a polarity bit of 0 sets it on a 1-to-0 change. No other change sets status in this mode.
- R6: In edge mode, a both-edge flag of 1 sets status on either change, whatever the polarity bit. In level mode the both-edge flag has no effect.
- R7: Trigger registers are at addresses 5, 6 and 7, for pins 0-7, 8-15 and 16-23. Pin p uses bit p mod 8 of the register as polarity and bit 8 + p mod 8 as the both-edge flag. These registers read back as written.
- R8: A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged. If a detection falls in the same cycle as the clear of that bit, the bit stays set.
- R9: A pin configured as an output never sets its status bit, whatever its trigger settings and input value.
- R10: `irq` is 1 exactly when some pin has both its status bit and its enable bit (address 3/11) set.
- R11: After reset all registers read 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Read data, registered |
| pin_in | input | 24 | Pin input values |
| pin_out | output | 24 | Pin drive values |
| pin_oe | output | 24 | Pin output enables |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A host clear of a status bit can land in the same cycle as a new detection on that pin. This happens in two ways:

- A level condition still holds while the clear is written. The bench provokes this with a low-level pin held low, clears the bit, and reads the bit back as set.
- A rising edge reaches detection on the clock edge that takes the clear. The bench times the write for this case and expects the bit to survive.

A zero write is then shown to leave the bit set, and a one write is shown to clear it.

// File: rtl/pin_irq_gpio.sv
module pin_irq_gpio #(
  parameter int NPIN   = 24,
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int HI_OFS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            rd,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int GP   = 8;
  localparam int NGRP = NPIN / GP;
  localparam int HW   = NPIN - DW;
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_TYP  = AW'(2);
  localparam logic [AW-1:0] A_EN   = AW'(3);
  localparam logic [AW-1:0] A_ST   = AW'(4);
  localparam int            A_TRG  = 5;
  localparam logic [AW-1:0] A_DATA_H = AW'(0 + HI_OFS);
  localparam logic [AW-1:0] A_DIR_H  = AW'(1 + HI_OFS);
  localparam logic [AW-1:0] A_TYP_H  = AW'(2 + HI_OFS);
  localparam logic [AW-1:0] A_EN_H   = AW'(3 + HI_OFS);
  localparam logic [AW-1:0] A_ST_H   = AW'(4 + HI_OFS);

  logic [NPIN-1:0] dout, dir, typ, en, st;
  logic [NGRP*2*GP-1:0] trg;
  logic [NPIN-1:0] s1, s2, s3;
  logic [NPIN-1:0] set, clr, pin_val;
  logic [DW-1:0]   rmux;

  assign pin_out = dout;
  assign pin_oe  = dir;
  assign irq     = |(st & en);
  assign pin_val = (dir & dout) | (~dir & s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; dir <= '0; typ <= '0; en <= '0; trg <= '0;
    end else if (wr) begin
      case (addr)
        A_DATA:   dout[DW-1:0]   <= wdata;
        A_DATA_H: dout[NPIN-1:DW] <= wdata[HW-1:0];
        A_DIR:    dir[DW-1:0]    <= wdata;
        A_DIR_H:  dir[NPIN-1:DW]  <= wdata[HW-1:0];
        A_TYP:    typ[DW-1:0]    <= wdata;
        A_TYP_H:  typ[NPIN-1:DW]  <= wdata[HW-1:0];
        A_EN:     en[DW-1:0]     <= wdata;
        A_EN_H:   en[NPIN-1:DW]   <= wdata[HW-1:0];
        default: begin
          for (int g = 0; g < NGRP; g++)
            if (addr == AW'(A_TRG + g)) trg[g*2*GP +: 2*GP] <= wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  assign clr[DW-1:0]   = (wr && addr == A_ST)   ? wdata : '0;
  assign clr[NPIN-1:DW] = (wr && addr == A_ST_H) ? wdata[HW-1:0] : '0;

  for (genvar p = 0; p < NPIN; p++) begin : g_det
    logic pol, both, rise, fall;
    assign pol  = trg[(p/GP)*2*GP + p%GP];
    assign both = trg[(p/GP)*2*GP + GP + p%GP];
    assign rise = s2[p] & ~s3[p];
    assign fall = ~s2[p] & s3[p];
    assign set[p] = ~dir[p] & (typ[p] ? (both ? (rise | fall) : (pol ? rise : fall))
                                      : (s2[p] == pol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | set;
  end

  always_comb begin
    rmux = '0;
    case (addr)
      A_DATA:   rmux = pin_val[DW-1:0];
      A_DATA_H: rmux = DW'(pin_val[NPIN-1:DW]);
      A_DIR:    rmux = dir[DW-1:0];
      A_DIR_H:  rmux = DW'(dir[NPIN-1:DW]);
      A_TYP:    rmux = typ[DW-1:0];
      A_TYP_H:  rmux = DW'(typ[NPIN-1:DW]);
      A_EN:     rmux = en[DW-1:0];
      A_EN_H:   rmux = DW'(en[NPIN-1:DW]);
      A_ST:     rmux = st[DW-1:0];
      A_ST_H:   rmux = DW'(st[NPIN-1:DW]);
      default: begin
        for (int g = 0; g < NGRP; g++)
          if (addr == AW'(A_TRG + g)) rmux = trg[g*2*GP +: 2*GP];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_DIR) |=> (pin_oe[DW-1:0] == $past(wdata)));

  p_hi_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_DATA_H) |=> (rdata[DW-1:HW] == '0));

  p_w1c_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st) & ~st) & ~$past(clr)) == '0));

  p_output_no_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((st & ~$past(st)) & $past(dir)) == '0));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr && addr == A_EN && wdata == '0) && pin_oe[NPIN-1:0] == pin_oe &&
     en[NPIN-1:DW] == '0) |-> !irq);
endmodule

// File: tb/pin_irq_gpio_test.sv
module pin_irq_gpio_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic        wr = 0, rd = 0;
  logic [15:0] rdata;
  logic [23:0] pin_in = 0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_irq_gpio uut (.clk, .rst_n, .addr, .wdata, .wr, .rd, .rdata,
                    .pin_in, .pin_out, .pin_oe, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd = 1;
    @(posedge clk); @(negedge clk);
    rd = 0; d = rdata;
  endtask

  task automatic wr24(input logic [3:0] a, input logic [23:0] d);
    wr16(a, d[15:0]);
    wr16(a + 4'd8, {8'h00, d[23:16]});
  endtask

  task automatic rd24(input logic [3:0] a, output logic [23:0] d);
    logic [15:0] lo, hi;
    rd16(a, lo);
    rd16(a + 4'd8, hi);
    d = {hi[7:0], lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] v, dirv, datv, pinv;
    logic [15:0] h;
    idle(3);
    chk("R11 pin_oe", pin_oe, 0);
    chk("R11 pin_out", pin_out, 0);
    chk("R11 irq", irq, 0);
    rst_n = 1;
    idle(2);
    rd24(4'd1, v); chk("R11 dir", v, 0);
    rd24(4'd3, v); chk("R11 en", v, 0);
    rd16(4'd5, h); chk("R11 trig", h, 0);

    for (int k = 0; k < 8; k++) begin
      dirv = (24'h5A3C96 << (k*3)) | (24'h5A3C96 >> (24 - k*3));
      datv = ~dirv ^ (24'h111111 * k);
      pinv = 24'h0F1E2D * (k + 1);
      wr24(4'd1, dirv);
      wr24(4'd0, datv);
      pin_in = pinv;
      idle(4);
      chk("R1 pin_oe", pin_oe, dirv);
      chk("R1 pin_out", pin_out, datv);
      rd24(4'd0, v);  chk("R3 data read", v, (dirv & datv) | (~dirv & pinv));
      rd24(4'd1, v);  chk("R2 dir read", v, dirv);
      rd16(4'd9, h);  chk("R2 hi upper zero", h[15:8], 0);
    end

    wr24(4'd1, 24'h0); pin_in = 24'h000000; idle(4);
    pin_in = 24'hA5C3F0;
    begin
      logic [15:0] r0, r1, r2;
      rd16(4'd0, r0); rd16(4'd0, r1); rd16(4'd0, r2);
      chk("R3 sync e0 old", r0, 16'h0000);
      chk("R3 sync e1 old", r1, 16'h0000);
      chk("R3 sync e2 new", r2, 16'hC3F0);
    end

    for (int g = 0; g < 3; g++) wr16(4'(5 + g), 16'h1234 * (g + 3));
    for (int g = 0; g < 3; g++) begin
      rd16(4'(5 + g), h); chk("R7 trig read", h, 16'h1234 * (g + 3));
    end

    pin_in = 0;
    for (int p = 0; p < 24; p++) begin
      for (int m = 0; m < 6; m++) begin
        logic [3:0] tbl;
        logic tp, pl, bo;
        logic [15:0] tr;
        string tg;
        case (m)
          0: tbl = 4'b1110; 1: tbl = 4'b1011; 2: tbl = 4'b0010;
          3: tbl = 4'b1000; 4: tbl = 4'b1010; default: tbl = 4'b1110;
        endcase
        case (m)
          0: tg = "R4 level-high"; 1: tg = "R4 level-low"; 2: tg = "R5 rise";
          3: tg = "R5 fall"; 4: tg = "R6 both-edge"; default: tg = "R6 both ignored in level";
        endcase
        tp = (m >= 2 && m <= 4);
        pl = (m == 0 || m == 2 || m == 5 || (m == 4 && p % 2 == 0));
        bo = (m == 4 || m == 5);
        pin_in = 0;
        wr24(4'd1, ~(24'h1 << p));
        wr24(4'd2, tp ? (24'h1 << p) : 24'h0);
        for (int g = 0; g < 3; g++) begin
          tr = 0;
          if (g == p / 8) tr = (16'(pl) << (p % 8)) | (16'(bo) << (8 + p % 8));
          wr16(4'(5 + g), tr);
        end
        wr24(4'd3, 24'h1 << p);
        idle(4);
        wr24(4'd4, 24'hFFFFFF);
        idle(2);
        rd24(4'd4, v); chk({tg, " ph0 status R9"}, v, 24'(tbl[0]) << p);
        chk({tg, " ph0 irq R10"}, irq, tbl[0]);
        pin_in = 24'h1 << p; idle(4);
        rd24(4'd4, v); chk({tg, " ph1 status"}, v, 24'(tbl[1]) << p);
        chk({tg, " ph1 irq R10"}, irq, tbl[1]);
        wr24(4'd4, 24'hFFFFFF); idle(2);
        rd24(4'd4, v); chk({tg, " ph2 status R8"}, v, 24'(tbl[2]) << p);
        pin_in = 0; idle(4);
        rd24(4'd4, v); chk({tg, " ph3 status"}, v, 24'(tbl[3]) << p);
        chk({tg, " ph3 irq R10"}, irq, tbl[3]);
        if (m == 0) begin
          wr24(4'd3, 24'h0);
          chk("R10 masked irq", irq, 0);
        end
      end
    end

    wr24(4'd1, ~24'h8);
    wr24(4'd2, 24'h8);
    wr16(4'd5, 16'h0008); wr16(4'd6, 0); wr16(4'd7, 0);
    pin_in = 0; idle(4);
    wr24(4'd4, 24'hFFFFFF); idle(2);
    rd24(4'd4, v); chk("R8 collide pre", v, 0);
    pin_in = 24'h8;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr16(4'd4, 16'h0008);
    rd24(4'd4, v); chk("R8 set wins over clear", v, 24'h8);
    wr16(4'd4, 16'h0000);
    rd24(4'd4, v); chk("R8 zero write no effect", v, 24'h8);
    wr16(4'd4, 16'h0008);
    rd24(4'd4, v); chk("R8 one write clears", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule